// File: doc/BRIEF.md
# Dark-Column Black-Level Subtractor

This block sits on the pixel stream of a line-scanned image sensor and removes the black level from the image pixels. It counts the positions of the valid samples from the line-start marker. The leading empty positions are skipped. The light-shielded columns at each side of the image area are averaged, but only the trustworthy inner columns of each dark band are used. The outer column of each band is left out because light leaks into it.

The mean of the leading band is formed by multiplying by a fixed reciprocal. It is ready before the first image pixel reaches the output, so every image pixel of a line is corrected with a reference taken from that same line. A mode input can blend in the trailing-band mean of the previous line. Image pixels leave as the pixel minus the reference, clamped at zero. All other samples pass through unchanged. Every sample appears at the output a fixed two clocks after it was presented, with its valid and line-start flags.

Top module: `dark_ref_sub`

## Requirements
- R1: While reset is asserted and after it is released, valid_o, pix_o and black_o are 0 until the first sample comes through.
- R2: Each sample presented with valid_i high appears on the output exactly two clock cycles later, with valid_o high and with sol_o equal to its sol_i. No other output samples are produced.
- R3: Positions 0 to EMPTY_N-1 of a line are empty and have no effect on black_o. Position 0 is the sample marked by sol_i, and later positions count the valid samples after it.
- R4: The leading dark band covers positions EMPTY_N to EMPTY_N+LEAD_N-1. Its reference is floor(sum/(LEAD_N-2)) over the inner positions EMPTY_N+1 to EMPTY_N+LEAD_N-2. The first and last column of the band are excluded.
- R5: Image positions IMG_LO = EMPTY_N+LEAD_N to IMG_LO+ACT_N-1 leave with img_o = 1 and pix_o = pix - black_o, where black_o is the reference of that line.
- R6: When an image pixel is below the reference, pix_o is 0.
- R7: Samples outside the image positions leave unchanged, with img_o = 0.
- R8: The trailing band starts at IMG_LO+ACT_N and is TRAIL_N columns wide. Its mean is floor(sum/(TRAIL_N-2)) over its inner columns. When trail_mode_i is 1 at the end of a leading band, and a trailing mean has been taken since reset, the reference is (lead + trail + 1) >> 1, using the trailing mean of the most recent complete line.
- R9: With trail_mode_i = 0, the trailing mean has no effect and the reference equals the leading-band mean of the same line.
- R10: black_o changes at most once per line, at the end of the inner leading band. It stays stable while image pixels are output and after the line has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input sample qualifier |
| sol_i | input | 1 | Marks the first sample of a line (with valid_i) |
| pix_i | input | DATA_W | Input sample |
| trail_mode_i | input | 1 | 1: blend the previous line's trailing-band mean into the reference |
| valid_o | output | 1 | Output sample qualifier |
| sol_o | output | 1 | Line start, delayed with the sample |
| img_o | output | 1 | Output sample is a corrected image pixel |
| pix_o | output | DATA_W | Corrected or passed-through sample |
| black_o | output | DATA_W | Reference currently applied |

## Verification
The assertions assume that the black level changes only between the inner leading band and the image area. They also assume that every line begins with a sol_i pulse on a valid sample, so that the pipeline's fixed two-cycle delay lines up an output with the input two clocks earlier. The stimulus always sends complete lines that start with sol_i. It inserts random idle cycles between samples and between lines, holds trail_mode_i steady through each line, and keeps dark values small so that image values both above and below the reference occur.

// File: rtl/dark_ref_pkg.sv
package dark_ref_pkg;

  typedef struct packed {
    logic valid;
    logic sol;
    logic img;
    logic lead_add;
    logic lead_last;
    logic trail_add;
    logic trail_last;
  } px_flags_t;

  localparam int NUM_BANDS = 2;

endpackage

// File: rtl/dark_pos_track.sv
module dark_pos_track
  import dark_ref_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int EMPTY_N = 4,
  parameter int LEAD_N  = 20,
  parameter int ACT_N   = 4033,
  parameter int TRAIL_N = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sol_i,
  input  logic [DATA_W-1:0] pix_i,
  output px_flags_t         flags_o,
  output logic [DATA_W-1:0] pix_o
);

  localparam int LINE_N  = EMPTY_N + LEAD_N + ACT_N + TRAIL_N;
  localparam int POS_W   = $clog2(LINE_N + 1);
  localparam int LEAD_LO = EMPTY_N + 1;
  localparam int LEAD_HI = EMPTY_N + LEAD_N - 2;
  localparam int IMG_LO  = EMPTY_N + LEAD_N;
  localparam int IMG_HI  = IMG_LO + ACT_N - 1;
  localparam int TRL_LO  = IMG_HI + 2;
  localparam int TRL_HI  = IMG_HI + TRAIL_N - 1;

  localparam logic [POS_W-1:0] P_LEAD_LO = POS_W'(LEAD_LO);
  localparam logic [POS_W-1:0] P_LEAD_HI = POS_W'(LEAD_HI);
  localparam logic [POS_W-1:0] P_IMG_LO  = POS_W'(IMG_LO);
  localparam logic [POS_W-1:0] P_IMG_HI  = POS_W'(IMG_HI);
  localparam logic [POS_W-1:0] P_TRL_LO  = POS_W'(TRL_LO);
  localparam logic [POS_W-1:0] P_TRL_HI  = POS_W'(TRL_HI);
  localparam logic [POS_W-1:0] P_LINE    = POS_W'(LINE_N);

  logic [POS_W-1:0] pos_q, pos_cur;
  px_flags_t        flags_d;

  assign pos_cur = sol_i ? '0 : pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
    end else if (valid_i) begin
      // saturate past the line end
      pos_q <= (pos_cur == P_LINE) ? pos_cur : pos_cur + 1'b1;
    end
  end

  always_comb begin
    flags_d            = '0;
    flags_d.valid      = valid_i;
    flags_d.sol        = valid_i & sol_i;
    flags_d.img        = valid_i & (pos_cur >= P_IMG_LO) & (pos_cur <= P_IMG_HI);
    flags_d.lead_add   = valid_i & (pos_cur >= P_LEAD_LO) & (pos_cur <= P_LEAD_HI);
    flags_d.lead_last  = valid_i & (pos_cur == P_LEAD_HI);
    flags_d.trail_add  = valid_i & (pos_cur >= P_TRL_LO) & (pos_cur <= P_TRL_HI);
    flags_d.trail_last = valid_i & (pos_cur == P_TRL_HI);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o <= '0;
      pix_o   <= '0;
    end else begin
      flags_o <= flags_d;
      pix_o   <= pix_i;
    end
  end

endmodule

// File: rtl/dark_band_mean.sv
module dark_band_mean #(
  parameter int DATA_W = 12,
  parameter int N      = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              add_i,
  input  logic              last_i,
  input  logic [DATA_W-1:0] pix_i,
  output logic              done_o,
  output logic [DATA_W-1:0] mean_o
);

  localparam int N_W    = $clog2(N + 1);
  localparam int SUM_W  = DATA_W + N_W;
  // wide enough that floor(x*RECIP >> K) == floor(x/N) for every x < 2^SUM_W
  localparam int K      = SUM_W + N_W + 1;
  localparam int PROD_W = SUM_W + K + 1;
  localparam longint unsigned ONE_K = 64'd1 << K;
  localparam logic [K:0] RECIP = (K+1)'((ONE_K + longint'(N) - 1) / longint'(N));

  logic [SUM_W-1:0]  acc_q, total;
  logic [PROD_W-1:0] prod;

  assign total = acc_q + SUM_W'(pix_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (clr_i) begin
      acc_q <= '0;
    end else if (add_i) begin
      acc_q <= last_i ? '0 : total;
    end
  end

  assign prod   = PROD_W'(total) * PROD_W'(RECIP);
  assign mean_o = DATA_W'(prod >> K);
  assign done_o = add_i & last_i;

endmodule

// File: rtl/dark_pix_correct.sv
module dark_pix_correct
  import dark_ref_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  px_flags_t         flags_i,
  input  logic [DATA_W-1:0] pix_i,
  input  logic [DATA_W-1:0] ref_i,
  output logic              valid_o,
  output logic              sol_o,
  output logic              img_o,
  output logic [DATA_W-1:0] pix_o
);

  logic [DATA_W:0]   diff;
  logic [DATA_W-1:0] corr;

  assign diff = {1'b0, pix_i} - {1'b0, ref_i};
  assign corr = diff[DATA_W] ? '0 : diff[DATA_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sol_o   <= 1'b0;
      img_o   <= 1'b0;
      pix_o   <= '0;
    end else begin
      valid_o <= flags_i.valid;
      sol_o   <= flags_i.sol;
      img_o   <= flags_i.img;
      pix_o   <= flags_i.img ? corr : pix_i;
    end
  end

endmodule

// File: rtl/dark_ref_sub.sv
module dark_ref_sub
  import dark_ref_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int EMPTY_N = 4,
  parameter int LEAD_N  = 20,
  parameter int ACT_N   = 4033,
  parameter int TRAIL_N = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sol_i,
  input  logic [DATA_W-1:0] pix_i,
  input  logic              trail_mode_i,
  output logic              valid_o,
  output logic              sol_o,
  output logic              img_o,
  output logic [DATA_W-1:0] pix_o,
  output logic [DATA_W-1:0] black_o
);

  px_flags_t         s1_flags;
  logic [DATA_W-1:0] s1_pix;

  dark_pos_track #(
    .DATA_W (DATA_W),
    .EMPTY_N(EMPTY_N),
    .LEAD_N (LEAD_N),
    .ACT_N  (ACT_N),
    .TRAIL_N(TRAIL_N)
  ) u_pos (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .sol_i  (sol_i),
    .pix_i  (pix_i),
    .flags_o(s1_flags),
    .pix_o  (s1_pix)
  );

  logic [NUM_BANDS-1:0]             band_add, band_last, band_done;
  logic [NUM_BANDS-1:0][DATA_W-1:0] band_mean;

  assign band_add  = {s1_flags.trail_add,  s1_flags.lead_add};
  assign band_last = {s1_flags.trail_last, s1_flags.lead_last};

  for (genvar b = 0; b < NUM_BANDS; b++) begin : g_band
    localparam int BAND_CNT = (b == 0) ? LEAD_N - 2 : TRAIL_N - 2;
    dark_band_mean #(
      .DATA_W(DATA_W),
      .N     (BAND_CNT)
    ) u_mean (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (s1_flags.sol),
      .add_i (band_add[b]),
      .last_i(band_last[b]),
      .pix_i (s1_pix),
      .done_o(band_done[b]),
      .mean_o(band_mean[b])
    );
  end

  logic [DATA_W-1:0] ref_q, trail_q, ref_d;
  logic              trail_vld_q;
  logic [DATA_W:0]   mix_sum;

  assign mix_sum = {1'b0, band_mean[0]} + {1'b0, trail_q} + 1'b1;
  assign ref_d   = (trail_mode_i && trail_vld_q) ? mix_sum[DATA_W:1] : band_mean[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q       <= '0;
      trail_q     <= '0;
      trail_vld_q <= 1'b0;
    end else begin
      if (band_done[0]) ref_q <= ref_d;
      if (band_done[1]) begin
        trail_q     <= band_mean[1];
        trail_vld_q <= 1'b1;
      end
    end
  end

  assign black_o = ref_q;

  dark_pix_correct #(
    .DATA_W(DATA_W)
  ) u_corr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flags_i(s1_flags),
    .pix_i  (s1_pix),
    .ref_i  (ref_q),
    .valid_o(valid_o),
    .sol_o  (sol_o),
    .img_o  (img_o),
    .pix_o  (pix_o)
  );

endmodule

// File: rtl/dark_ref_chk.sv
module dark_ref_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              sol_i,
  input logic [DATA_W-1:0] pix_i,
  input logic              valid_o,
  input logic              sol_o,
  input logic              img_o,
  input logic [DATA_W-1:0] pix_o,
  input logic [DATA_W-1:0] black_o
);

  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 1'b1;
  end

  logic hist2, hist1;
  assign hist2 = (cyc_q >= 2'd2);
  assign hist1 = (cyc_q >= 2'd1);

  // R2
  valid_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hist2 |-> (valid_o == $past(valid_i, 2)));

  // R2
  sol_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hist2 |-> (sol_o == ($past(sol_i, 2) && $past(valid_i, 2))));

  // R5
  img_sub_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hist2 && valid_o && img_o && pix_o != '0) |->
      (({1'b0, pix_o} + {1'b0, black_o}) == {1'b0, $past(pix_i, 2)}));

  // R6
  img_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hist2 && valid_o && img_o && pix_o == '0) |-> ($past(pix_i, 2) <= black_o));

  // R7
  pass_thru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hist2 && valid_o && !img_o) |-> (pix_o == $past(pix_i, 2)));

  // R10
  ref_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hist1 && valid_o && img_o) |-> $stable(black_o));

  // R2
  img_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (img_o || sol_o) |-> valid_o);

endmodule

bind dark_ref_sub dark_ref_chk #(.DATA_W(DATA_W)) u_dark_ref_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .sol_i  (sol_i),
  .pix_i  (pix_i),
  .valid_o(valid_o),
  .sol_o  (sol_o),
  .img_o  (img_o),
  .pix_o  (pix_o),
  .black_o(black_o)
);

// File: tb/dark_ref_sub_bench.sv
module dark_ref_sub_bench;

  localparam int CLK_P   = 10;
  localparam int DATA_W  = 12;
  localparam int EMPTY_N = 4;
  localparam int LEAD_N  = 20;
  localparam int ACT_N   = 30;
  localparam int TRAIL_N = 19;
  localparam int LINE_N  = EMPTY_N + LEAD_N + ACT_N + TRAIL_N;
  localparam int IMG_LO  = EMPTY_N + LEAD_N;
  localparam int IMG_HI  = IMG_LO + ACT_N - 1;
  localparam int MAXV    = (1 << DATA_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              valid_i = 1'b0, sol_i = 1'b0, trail_mode_i = 1'b0;
  logic [DATA_W-1:0] pix_i = '0;
  logic              valid_o, sol_o, img_o;
  logic [DATA_W-1:0] pix_o, black_o;

  always #(CLK_P/2) clk = ~clk;

  dark_ref_sub #(
    .DATA_W(DATA_W), .EMPTY_N(EMPTY_N), .LEAD_N(LEAD_N),
    .ACT_N(ACT_N), .TRAIL_N(TRAIL_N)
  ) u_dark_ref_sub (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .sol_i(sol_i),
    .pix_i(pix_i), .trail_mode_i(trail_mode_i), .valid_o(valid_o),
    .sol_o(sol_o), .img_o(img_o), .pix_o(pix_o), .black_o(black_o)
  );

  int checks = 0, errors = 0, cyc = 0, n_in = 0, n_out = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  int    q_stamp[$], q_pix[$], q_img[$], q_sol[$], q_ref[$];
  string q_tag[$], q_rtag[$];

  task automatic chk(string tag, bit ok, int act, int exp, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int mean_floor(int sum, int n);
    return sum / n;
  endfunction

  function automatic int sat_sub(int p, int r);
    return (p > r) ? p - r : 0;
  endfunction

  // output monitor
  always @(negedge clk) begin
    if (rst_n && valid_o && !done) begin
      n_out++;
      if (q_pix.size() == 0) begin
        chk("R2", 0, 1, 0, "unexpected output sample");
      end else begin
        int st, ep, ei, es, er;
        string tg, rt;
        st = q_stamp.pop_front(); ep = q_pix.pop_front(); ei = q_img.pop_front();
        es = q_sol.pop_front();   er = q_ref.pop_front(); tg = q_tag.pop_front();
        rt = q_rtag.pop_front();
        chk("R2", cyc == st + 2, cyc - st, 2, "latency");
        chk("R2", int'(sol_o) == es, int'(sol_o), es, "sol_o");
        chk(tg, int'(img_o) == ei, int'(img_o), ei, "img_o");
        chk(tg, int'(pix_o) == ep, int'(pix_o), ep, "pix_o");
        if (ei != 0) chk(rt, int'(black_o) == er, int'(black_o), er, "black_o");
      end
    end
  end

  // bench model of the trailing reference
  int tm = 0;
  bit tv = 0;

  task automatic send(int p, bit s);
    valid_i = 1'b1; sol_i = s; pix_i = DATA_W'(p);
    q_stamp.push_back(cyc);
    n_in++;
    @(negedge clk);
    valid_i = 1'b0; sol_i = 1'b0;
    if ($urandom % 4 == 0) repeat (1 + $urandom % 2) @(negedge clk);
  endtask

  // kind: 0 random, 1 hot empty/edge columns, 2 image below reference
  task automatic run_line(bit mode, int kind);
    int px[LINE_N];
    int lsum = 0, tsum = 0, lead, rf;
    string rtag;
    for (int i = 0; i < LINE_N; i++) begin
      if (i >= IMG_LO && i <= IMG_HI) px[i] = (kind == 2) ? 100 + $urandom % 60 : $urandom % (MAXV + 1);
      else px[i] = 150 + $urandom % 200;
    end
    if (kind == 1) begin
      for (int i = 0; i < EMPTY_N; i++) px[i] = MAXV;
      px[EMPTY_N] = MAXV;
      px[IMG_LO - 1] = MAXV;
    end
    for (int i = EMPTY_N + 1; i <= IMG_LO - 2; i++) lsum += px[i];
    for (int i = IMG_HI + 2; i <= IMG_HI + TRAIL_N - 1; i++) tsum += px[i];
    lead = mean_floor(lsum, LEAD_N - 2);
    if (mode && tv) begin rf = (lead + tm + 1) / 2; rtag = "R8"; end
    else begin rf = lead; rtag = (tv && !mode) ? "R9" : "R4"; end
    if (kind == 1) rtag = "R3";
    for (int i = 0; i < LINE_N; i++) begin
      bit im = (i >= IMG_LO && i <= IMG_HI);
      q_pix.push_back(im ? sat_sub(px[i], rf) : px[i]);
      q_img.push_back(im ? 1 : 0);
      q_sol.push_back(i == 0 ? 1 : 0);
      q_ref.push_back(rf);
      q_tag.push_back(im ? ((px[i] < rf) ? "R6" : "R5") : "R7");
      q_rtag.push_back(rtag);
    end
    trail_mode_i = mode;
    for (int i = 0; i < LINE_N; i++) send(px[i], i == 0);
    repeat (4) @(negedge clk);
    chk("R10", int'(black_o) == rf, int'(black_o), rf, "black_o after line");
    tm = mean_floor(tsum, TRAIL_N - 2);
    tv = 1;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0d4c));
    repeat (3) @(negedge clk);
    // R1
    chk("R1", valid_o == 1'b0, int'(valid_o), 0, "valid_o in reset");
    chk("R1", black_o == '0, int'(black_o), 0, "black_o in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", valid_o == 1'b0 && pix_o == '0, int'(pix_o), 0, "idle after reset");
    chk("R1", black_o == '0, int'(black_o), 0, "black_o after reset");

    run_line(1'b1, 1);   // R3, R4: hot empty and edge columns, no trailing mean yet
    run_line(1'b0, 2);   // R6, R9
    run_line(1'b1, 2);   // R8 with clamp
    for (int l = 0; l < 14; l++) run_line(1'($urandom % 2), 0);
    run_line(1'b0, 1);

    repeat (5) @(negedge clk);
    chk("R2", n_out == n_in, n_out, n_in, "output sample count");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule